// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-side register file of a two-channel asynchronous serial controller. Each channel offers the host two ports on a shared single-access bus: a control port and a data port. Control registers are not memory-mapped. The host first writes a register index to the control port, and the next control-port access, read or write, reaches the indexed register. Any control access made while the pointer is zero reaches the command register (on a write) or the line status register (on a read).

The block keeps the per-channel write registers and the master register that both channels share. It decodes the inline commands and collects interrupt-pending flags from abstract serializer events. It returns line status and a combined pending byte, and drives a single interrupt line. The serializers and the baud generator are outside the block. Their state arrives as level status inputs and one-cycle event pulses. Transmit data leaves the block as a load strobe with a byte.

Channel index 1 is channel A and index 0 is channel B on every two-bit per-channel port.

Top module: `scc_regif`

## Requirements
- R1: A control-port write while a channel's pointer is 0 loads the pointer with {bits 5:3 == 1, bits 2:0} of the written byte. Any control-port access while the pointer is non-zero reaches that register, and the pointer then returns to 0. A control read at pointer 0 leaves it at 0.
- R2: A control read at pointer 0 returns line status: bit 0 receive character available, bit 2 transmit buffer empty, bit 3 carrier detect, bit 5 clear-to-send, bit 7 break. All other bits are 0.
- R3: A control read at index 3 on either channel returns the pending byte. Bits 2:0 are channel B's {receive, transmit, external} pending flags and bits 5:3 are channel A's. Bits 7:6 are 0.
- R4: A write at pointer 0 carries a command in bits 5:3. Command 2 clears the channel's external pending flag and command 5 clears its transmit pending flag. Commands 0, 1 and 6 clear nothing. If a flag is set and cleared in the same cycle, the set wins.
- R5: In write register 1, bit 0 enables external-status pending and bit 1 enables transmit pending. An event whose enable bit is 0 sets nothing.
- R6: Write register 1 bits 4:3 select the receive mode. Mode 0 never sets receive pending. Mode 1 sets it only for the first character after write register 1 is written or the channel is reset. Mode 2 sets it for every character. A data-port read returns that channel's received byte and clears its receive pending flag.
- R7: Transmit pending stays set until command 5 or a data-port write on that channel. A data-port write pulses that channel's bit of tx_load for one cycle with tx_byte equal to the written byte.
- R8: irq is high exactly when bit 3 of the master register (index 9) is set and at least one pending flag of either channel is set.
- R9: A write to index 9 stores bits 5:0, and bits 7:6 always read back 0. Bits 7:6 of that write select a reset: 1 resets channel B, 2 resets channel A, 3 resets both channels and clears the master register. A channel reset clears that channel's write registers, pointer and pending flags, and re-arms mode 1.
- R10: Control reads at any index other than 0, 3 and 9 return the value last written to that channel's register at that index. Index 9 is shared by both channels. rst_n low clears all registers, pointers and flags.
- R11: Reads return 0 on bus_rdata when no read access is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_ch | input | 1 | 1 channel A, 0 channel B |
| bus_sel_data | input | 1 | 1 data port, 0 control port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the access cycle |
| st_rx_avail | input | 2 | Receive character available per channel |
| st_tx_empty | input | 2 | Transmit buffer empty per channel |
| st_dcd | input | 2 | Carrier detect per channel |
| st_cts | input | 2 | Clear-to-send per channel |
| st_brk | input | 2 | Break detected per channel |
| ev_ext | input | 2 | External status change pulse per channel |
| ev_tx | input | 2 | Transmit buffer became empty pulse per channel |
| ev_rx | input | 2 | Character received pulse per channel |
| rx_byte | input | 16 | Received bytes, [15:8] channel A, [7:0] channel B |
| tx_load | output | 2 | Transmit load strobe per channel |
| tx_byte | output | 8 | Byte to load into the transmitter |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences come first. They program the enable register of one channel, raise a transmit event, then turn the master enable on and off around it, and issue command 5 and a channel reset. These show set, hold, clear and gating in isolation, with literal expected bytes. A long seeded random run follows. It mixes pointer loads (including the high-bank form), commands, reads and writes of every index, data-port traffic and event pulses on both channels. Comparing each read byte, irq and the load strobe against a bench model shows that the pointer returns to zero, that both channels have their own state, and that set-over-clear priority and the mode-1 re-arm hold when these events coincide in the same cycle. Rare master-register writes with the reset field set show whether a reset reaches only the selected channel.

// File: rtl/scc_regif_pkg.sv
`timescale 1ns/1ps
// Shared constants for the serial controller register front end.
// Register indices and inline command codes; field positions are
// fixed by the host programming model.
package scc_regif_pkg;
    localparam int DW         = 8;
    localparam int NREG       = 16;
    localparam int NCH        = 2;
    localparam int CMD_LSB    = 3;
    localparam int NPEND      = 3;

    localparam logic [3:0] IDX_STAT   = 4'd0;
    localparam logic [3:0] IDX_ENA    = 4'd1;
    localparam logic [3:0] IDX_PEND   = 4'd3;
    localparam logic [3:0] IDX_MASTER = 4'd9;

    localparam logic [2:0] CMD_HIGH    = 3'd1;
    localparam logic [2:0] CMD_RST_EXT = 3'd2;
    localparam logic [2:0] CMD_RST_TX  = 3'd5;

    // Pending flag positions inside one channel's group
    localparam int P_EXT = 0;
    localparam int P_TX  = 1;
    localparam int P_RX  = 2;
endpackage

// File: rtl/scc_chan.sv
`timescale 1ns/1ps
// Per-channel pointer and write-register file.
// Holds the register pointer and the write registers of one channel,
// and decodes the commands carried by a pointer-0 write.
// Assumes NREG == 16 so the pointer is the 3 low bits plus a high-bank bit.
module scc_chan
    import scc_regif_pkg::*;
#(
    parameter int NR = NREG,
    parameter int W  = DW,
    localparam int PW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          acc_ctl,
    input  logic          acc_wr,
    input  logic [W-1:0]  wdata,
    output logic [PW-1:0] ptr,
    output logic [W-1:0]  rd_wreg,
    output logic          ena_ext,
    output logic          ena_tx,
    output logic [1:0]    rx_mode,
    output logic          wr1_strobe,
    output logic          cmd_rst_ext,
    output logic          cmd_rst_tx
);
    logic [W-1:0] wregs [NR];
    logic [2:0]   cmd;
    logic         wr0_hit;

    // Command field and pointer-0 write detection
    assign cmd         = wdata[CMD_LSB +: 3];
    assign wr0_hit     = acc_ctl && acc_wr && (ptr == '0);
    assign cmd_rst_ext = wr0_hit && (cmd == CMD_RST_EXT);
    assign cmd_rst_tx  = wr0_hit && (cmd == CMD_RST_TX);
    assign wr1_strobe  = acc_ctl && acc_wr && (ptr == PW'(IDX_ENA));

    // Pointer: load on pointer-0 write, return to zero after any other access
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else if (acc_ctl) begin
            if (wr0_hit) ptr <= {cmd == CMD_HIGH, wdata[2:0]};
            else         ptr <= '0;
        end
    end

    // Write-register file, indices 1..NR-1
    always_ff @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (!rst_n || clr || i == 0)
                wregs[i] <= '0;
            else if (acc_ctl && acc_wr && ptr == PW'(i))
                wregs[i] <= wdata;
        end
    end

    // Read-back of the addressed write register and enable fields
    assign rd_wreg = wregs[ptr];
    assign ena_ext = wregs[IDX_ENA][0];
    assign ena_tx  = wregs[IDX_ENA][1];
    assign rx_mode = wregs[IDX_ENA][4:3];

    AST_PTR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ctl && ptr != '0) |=> (ptr == '0));                         // R1
    AST_CLR_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0 && rd_wreg == '0));                            // R9
endmodule

// File: rtl/scc_pend.sv
`timescale 1ns/1ps
// Interrupt-pending flags of one channel.
// Bit 0 external status, bit 1 transmit, bit 2 receive. Sets win over
// clears in the same cycle; a channel clear wins over everything.
module scc_pend
    import scc_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ena_ext,
    input  logic             ena_tx,
    input  logic [1:0]       rx_mode,
    input  logic             wr1_strobe,
    input  logic             ev_ext,
    input  logic             ev_tx,
    input  logic             ev_rx,
    input  logic             cmd_rst_ext,
    input  logic             cmd_rst_tx,
    input  logic             tx_load,
    input  logic             rx_read,
    output logic [NPEND-1:0] pend
);
    logic armed;
    logic set_ext, set_tx, set_rx, first_take;

    // Event qualification by the enable fields
    assign first_take = ev_rx && (rx_mode == 2'd1) && armed;
    assign set_ext    = ev_ext && ena_ext;
    assign set_tx     = ev_tx && ena_tx;
    assign set_rx     = (ev_rx && rx_mode == 2'd2) || first_take;

    // Pending flag update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend <= '0;
        end else begin
            pend[P_EXT] <= set_ext || (pend[P_EXT] && !cmd_rst_ext);
            pend[P_TX]  <= set_tx  || (pend[P_TX]  && !(cmd_rst_tx || tx_load));
            pend[P_RX]  <= set_rx  || (pend[P_RX]  && !rx_read);
        end
    end

    // First-character arm for receive mode 1
    always_ff @(posedge clk) begin
        if (!rst_n || clr)    armed <= 1'b1;
        else if (wr1_strobe)  armed <= 1'b1;
        else if (first_take)  armed <= 1'b0;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[P_TX] && !clr && !cmd_rst_tx && !tx_load) |=> pend[P_TX]);  // R7
    AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ext && !ena_ext && !pend[P_EXT]) |=> !pend[P_EXT]);          // R5
    AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && rx_mode == 2'd0 && !pend[P_RX]) |=> !pend[P_RX]);      // R6
    AST_CLR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pend == '0));                                            // R9
endmodule

// File: rtl/scc_regif.sv
`timescale 1ns/1ps
// Host register front end of a two-channel serial controller.
// Owns the shared master register, decodes its reset field, builds the
// status and pending read bytes and drives the interrupt line.
// Assumes one bus access per cycle; channel index 1 = A, 0 = B.
module scc_regif
    import scc_regif_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_wr,
    input  logic            bus_ch,
    input  logic            bus_sel_data,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NCH-1:0]  st_rx_avail,
    input  logic [NCH-1:0]  st_tx_empty,
    input  logic [NCH-1:0]  st_dcd,
    input  logic [NCH-1:0]  st_cts,
    input  logic [NCH-1:0]  st_brk,
    input  logic [NCH-1:0]  ev_ext,
    input  logic [NCH-1:0]  ev_tx,
    input  logic [NCH-1:0]  ev_rx,
    input  logic [NCH*DW-1:0] rx_byte,
    output logic [NCH-1:0]  tx_load,
    output logic [DW-1:0]   tx_byte,
    output logic            irq
);
    localparam int PW = $clog2(NREG);

    logic [PW-1:0]    ptr_c   [NCH];
    logic [DW-1:0]    wreg_c  [NCH];
    logic [NPEND-1:0] pend_c  [NCH];
    logic [NCH-1:0]   acc_ctl, rx_read, clr;
    logic [DW-1:0]    wr9_q;
    logic             wr9_hit, hw_rst;
    logic [1:0]       rst_sel;
    logic [PW-1:0]    cur_ptr;

    // Master-register write detection and reset field decode
    assign cur_ptr = ptr_c[bus_ch];
    assign wr9_hit = bus_en && bus_wr && !bus_sel_data && (cur_ptr == PW'(IDX_MASTER));
    assign rst_sel = wr9_hit ? bus_wdata[7:6] : 2'd0;
    assign hw_rst  = (rst_sel == 2'd3);
    assign clr[0]  = rst_sel[0];
    assign clr[1]  = rst_sel[1];

    // Shared master register; reset field is never stored
    always_ff @(posedge clk) begin
        if (!rst_n || hw_rst) wr9_q <= '0;
        else if (wr9_hit)     wr9_q <= {2'b00, bus_wdata[5:0]};
    end

    assign tx_byte = bus_wdata;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            logic ena_ext, ena_tx, wr1_strobe, cmd_rst_ext, cmd_rst_tx;
            logic [1:0] rx_mode;

            // Per-channel access qualification
            assign acc_ctl[c] = bus_en && !bus_sel_data && (bus_ch == c[0]);
            assign rx_read[c] = bus_en && !bus_wr && bus_sel_data && (bus_ch == c[0]);
            assign tx_load[c] = bus_en && bus_wr && bus_sel_data && (bus_ch == c[0]);

            scc_chan u_chan (
                .clk(clk), .rst_n(rst_n), .clr(clr[c]),
                .acc_ctl(acc_ctl[c]), .acc_wr(bus_wr), .wdata(bus_wdata),
                .ptr(ptr_c[c]), .rd_wreg(wreg_c[c]),
                .ena_ext(ena_ext), .ena_tx(ena_tx), .rx_mode(rx_mode),
                .wr1_strobe(wr1_strobe), .cmd_rst_ext(cmd_rst_ext),
                .cmd_rst_tx(cmd_rst_tx)
            );

            scc_pend u_pend (
                .clk(clk), .rst_n(rst_n), .clr(clr[c]),
                .ena_ext(ena_ext), .ena_tx(ena_tx), .rx_mode(rx_mode),
                .wr1_strobe(wr1_strobe), .ev_ext(ev_ext[c]), .ev_tx(ev_tx[c]),
                .ev_rx(ev_rx[c]), .cmd_rst_ext(cmd_rst_ext),
                .cmd_rst_tx(cmd_rst_tx), .tx_load(tx_load[c]),
                .rx_read(rx_read[c]), .pend(pend_c[c])
            );
        end
    endgenerate

    // Read-data multiplexer for the addressed port and register
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_wr) begin
            if (bus_sel_data) begin
                bus_rdata = rx_byte[bus_ch*DW +: DW];
            end else begin
                case (cur_ptr)
                    PW'(IDX_STAT):   bus_rdata = {st_brk[bus_ch], 1'b0, st_cts[bus_ch], 1'b0,
                                                  st_dcd[bus_ch], st_tx_empty[bus_ch], 1'b0,
                                                  st_rx_avail[bus_ch]};
                    PW'(IDX_PEND):   bus_rdata = {2'b00, pend_c[1], pend_c[0]};
                    PW'(IDX_MASTER): bus_rdata = wr9_q;
                    default:         bus_rdata = wreg_c[bus_ch];
                endcase
            end
        end
    end

    // Interrupt line: any pending flag, gated by the master enable
    assign irq = wr9_q[3] && ((|pend_c[0]) || (|pend_c[1]));

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr9_q[3] |-> !irq);                                              // R8
    AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hw_rst |=> (wr9_q == '0 && pend_c[0] == '0 && pend_c[1] == '0));  // R9
    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_load));                                               // R7
endmodule

// File: tb/sim_scc_regif.sv
`timescale 1ns/1ps
// Self-checking bench: directed sequences then seeded random traffic,
// compared against a behavioural model kept in bench variables.
module sim_scc_regif;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_wr, bus_ch, bus_sel_data;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [1:0]  st_rx_avail, st_tx_empty, st_dcd, st_cts, st_brk;
    logic [1:0]  ev_ext, ev_tx, ev_rx, tx_load;
    logic [15:0] rx_byte;
    logic [7:0]  tx_byte;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    scc_regif u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_ch(bus_ch), .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .st_rx_avail(st_rx_avail),
        .st_tx_empty(st_tx_empty), .st_dcd(st_dcd), .st_cts(st_cts),
        .st_brk(st_brk), .ev_ext(ev_ext), .ev_tx(ev_tx), .ev_rx(ev_rx),
        .rx_byte(rx_byte), .tx_load(tx_load), .tx_byte(tx_byte), .irq(irq)
    );

    // Bench model state
    int         m_ptr  [2];
    logic [7:0] m_wr   [2][16];
    logic [7:0] m_wr9;
    logic [2:0] m_pend [2];
    logic       m_arm  [2];
    logic [7:0] last_rd;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_ptr[k] = 0; m_pend[k] = '0; m_arm[k] = 1'b1;
            for (int i = 0; i < 16; i++) m_wr[k][i] = '0;
        end
        m_wr9 = '0;
    endtask

    function automatic logic [7:0] exp_rdata();
        int c = int'(bus_ch);
        if (!bus_en || bus_wr) return 8'h00;                       // R11
        if (bus_sel_data) return rx_byte[c*8 +: 8];                // R6
        case (m_ptr[c])
            0: return {st_brk[c], 1'b0, st_cts[c], 1'b0, st_dcd[c],
                       st_tx_empty[c], 1'b0, st_rx_avail[c]};       // R2
            3: return {2'b00, m_pend[1], m_pend[0]};                // R3
            9: return m_wr9;                                        // R9
            default: return m_wr[c][m_ptr[c]];                      // R10
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_wr9[3] && ((|m_pend[0]) || (|m_pend[1]));          // R8
    endfunction

    // Advance the model by one clock with the inputs now applied
    task automatic model_step();
        int c = int'(bus_ch);
        logic [1:0] rs = 2'd0;
        int np [2];
        logic [7:0] nw [2][16];
        logic [2:0] npend [2];
        logic narm [2];
        if (bus_en && bus_wr && !bus_sel_data && m_ptr[c] == 9) rs = bus_wdata[7:6];
        for (int k = 0; k < 2; k++) begin
            logic acc = bus_en && !bus_sel_data && (c == k);
            logic w0  = acc && bus_wr && m_ptr[k] == 0;
            logic r_ext = w0 && bus_wdata[5:3] == 3'd2;
            logic r_tx  = w0 && bus_wdata[5:3] == 3'd5;
            logic ld    = bus_en && bus_wr && bus_sel_data && (c == k);
            logic rr    = bus_en && !bus_wr && bus_sel_data && (c == k);
            logic w1    = acc && bus_wr && m_ptr[k] == 1;
            logic [1:0] md = m_wr[k][1][4:3];
            logic take = ev_rx[k] && md == 2'd1 && m_arm[k];
            logic s_ext = ev_ext[k] && m_wr[k][1][0];
            logic s_tx  = ev_tx[k] && m_wr[k][1][1];
            logic s_rx  = (ev_rx[k] && md == 2'd2) || take;
            npend[k][0] = s_ext || (m_pend[k][0] && !r_ext);
            npend[k][1] = s_tx  || (m_pend[k][1] && !(r_tx || ld));
            npend[k][2] = s_rx  || (m_pend[k][2] && !rr);
            narm[k] = w1 ? 1'b1 : (take ? 1'b0 : m_arm[k]);
            for (int i = 0; i < 16; i++) nw[k][i] = m_wr[k][i];
            np[k] = m_ptr[k];
            if (acc) begin
                if (w0) np[k] = (bus_wdata[5:3] == 3'd1 ? 8 : 0) + int'(bus_wdata[2:0]);
                else begin
                    if (bus_wr) nw[k][m_ptr[k]] = bus_wdata;
                    np[k] = 0;
                end
            end
            if (rs[k]) begin
                npend[k] = '0; narm[k] = 1'b1; np[k] = 0;
                for (int i = 0; i < 16; i++) nw[k][i] = '0;
            end
        end
        if (rs == 2'd3) m_wr9 = '0;
        else if (bus_en && bus_wr && !bus_sel_data && m_ptr[c] == 9)
            m_wr9 = {2'b00, bus_wdata[5:0]};
        for (int k = 0; k < 2; k++) begin
            m_ptr[k] = np[k]; m_pend[k] = npend[k]; m_arm[k] = narm[k];
            for (int i = 0; i < 16; i++) m_wr[k][i] = nw[k][i];
        end
    endtask

    // One bus cycle: drive at negedge, check mid-cycle, update at posedge
    task automatic cyc(logic en, logic wr, logic ch, logic sd, logic [7:0] wd);
        bus_en = en; bus_wr = wr; bus_ch = ch; bus_sel_data = sd; bus_wdata = wd;
        #1;
        last_rd = bus_rdata;
        if (en && !wr) chk(sd ? "R6 data read" : "R1/R2/R3/R10 control read",
                           bus_rdata, exp_rdata());
        else chk("R11 idle rdata", bus_rdata, 8'h00);
        chk("R8 irq", {7'b0, irq}, {7'b0, exp_irq()});
        chk("R7 tx_load", {6'b0, tx_load},
            {6'b0, (en && wr && sd) ? (ch ? 2'b10 : 2'b01) : 2'b00});
        if (en && wr && sd) chk("R7 tx_byte", tx_byte, wd);
        @(posedge clk);
        model_step();
        @(negedge clk);
        ev_ext = '0; ev_tx = '0; ev_rx = '0;
    endtask

    task automatic wreg(logic ch, logic [3:0] idx, logic [7:0] v);
        cyc(1, 1, ch, 0, {2'b00, idx[3] ? 3'd1 : 3'd0, idx[2:0]});
        cyc(1, 1, ch, 0, v);
    endtask

    task automatic rreg(logic ch, logic [3:0] idx);
        if (idx != 0) cyc(1, 1, ch, 0, {2'b00, idx[3] ? 3'd1 : 3'd0, idx[2:0]});
        cyc(1, 0, ch, 0, 8'h00);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; bus_en = 0; bus_wr = 0; bus_ch = 0; bus_sel_data = 0;
        bus_wdata = '0; ev_ext = '0; ev_tx = '0; ev_rx = '0;
        st_rx_avail = 2'b01; st_tx_empty = 2'b10; st_dcd = 2'b11;
        st_cts = 2'b00; st_brk = 2'b10; rx_byte = 16'hA55B;
        model_reset();
        repeat (3) @(negedge clk);
        chk("R10 reset irq", {7'b0, irq}, 8'h00);
        chk("R10 reset tx_load", {6'b0, tx_load}, 8'h00);
        rst_n = 1'b1;

        // R2: status layout for A (avail=0,txe=1,dcd=1,cts=0,brk=1)
        rreg(1, 0);
        chk("R2 status A literal", last_rd, 8'h8C);
        // R1/R10: program enable register of A, read it back
        wreg(1, 1, 8'h13);
        rreg(1, 1);
        chk("R10 readback literal", last_rd, 8'h13);
        // R1: high-bank pointer reaches index 13
        wreg(0, 13, 8'h5E);
        rreg(0, 13);
        chk("R1 high bank literal", last_rd, 8'h5E);
        // R5/R3: transmit event on A, pending seen at bit 4
        ev_tx = 2'b10; cyc(0, 0, 0, 0, 0);
        rreg(0, 3);
        chk("R3 pending literal", last_rd, 8'h10);
        // R8: master enable raises irq
        wreg(0, 9, 8'h08);
        #1 chk("R8 irq on", {7'b0, irq}, 8'h01);
        // R4: command 5 clears transmit pending
        cyc(1, 1, 1, 0, 8'h28);
        #1 chk("R4 irq off", {7'b0, irq}, 8'h00);
        // R5: external event on B with enable off sets nothing
        ev_ext = 2'b01; cyc(0, 0, 0, 0, 0);
        rreg(1, 3);
        chk("R5 gated literal", last_rd, 8'h00);
        // R9: reset A via master register, enables cleared, wr9 kept low bits
        wreg(0, 9, 8'h88);
        rreg(1, 1);
        chk("R9 chan reset literal", last_rd, 8'h00);
        rreg(0, 9);
        chk("R9 field reads 0", last_rd, 8'h08);
        // R6: mode 1 takes only the first character
        wreg(0, 1, 8'h08);
        ev_rx = 2'b01; cyc(1, 0, 0, 1, 0);
        chk("R6 data byte literal", last_rd, 8'h5B);
        ev_rx = 2'b01; cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 0, 1, 0);
        ev_rx = 2'b01; cyc(0, 0, 0, 0, 0);
        rreg(0, 3);
        chk("R6 first only literal", last_rd, 8'h00);
        // R9: full hardware reset
        wreg(1, 9, 8'hC8);
        rreg(0, 9);
        chk("R9 hw reset literal", last_rd, 8'h00);

        // Seeded random traffic
        for (int n = 0; n < 6000; n++) begin
            logic en = ($urandom % 10) < 7;
            logic sd = ($urandom % 4) == 0;
            logic wr = ($urandom % 10) < 6;
            logic ch = $urandom % 2;
            logic [7:0] wd = 8'($urandom);
            st_rx_avail = 2'($urandom); st_tx_empty = 2'($urandom);
            st_dcd = 2'($urandom); st_cts = 2'($urandom); st_brk = 2'($urandom);
            rx_byte = 16'($urandom);
            ev_ext = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            ev_tx  = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            ev_rx  = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            if (en && !sd && wr) begin
                if (m_ptr[ch] == 0) begin
                    int sel = $urandom % 6;
                    logic [3:0] idx = (sel == 0) ? 4'd1 : (sel == 1) ? 4'd3 :
                                      (sel == 2) ? 4'd9 : 4'($urandom);
                    logic [2:0] cm = (sel == 5) ? 3'($urandom) :
                                     (idx[3] ? 3'd1 : 3'd0);
                    wd = {2'($urandom), cm, idx[2:0]};
                end else if (m_ptr[ch] == 9) begin
                    if (($urandom % 10) != 0) wd[7:6] = 2'b00;
                end
            end
            cyc(en, wr, ch, sd, wd);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule